// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames. Software or a neighbouring block writes bytes into a small store. The store is a 16-entry first-in first-out queue when queueing is switched on, and a single holding slot when it is switched off. A frame engine takes one byte at a time from the store and sends it on a single output line. The shape of each frame comes from a set of line-control inputs: the character length, the parity mode, the number of stop bits and a break request.

Bit timing comes from a tick input driven from outside, running at sixteen times the bit rate. One bit lasts sixteen ticks. The block does not divide down a clock itself. Two status outputs report the state of the block. One reports that the store is empty. The other reports that the store is empty and the line is idle as well, so the last frame has fully left the block.

The line-control inputs are captured when a frame starts. A frame that is already on the line keeps its format if the inputs change. A flush pulse empties the store. A change of the queue-enable input also empties the store. Neither of them stops a frame that is already being sent.

Top module: `async_tx`

## Requirements
- R1: Each frame starts with a low start bit. The data bits follow, least significant bit first. The length code `word_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Each start, data and parity bit lasts exactly 16 ticks of `bit_tick`.
- R2: When `par_en` is 1 and `par_stick` is 0, one parity bit follows the data bits. With `par_even` at 1 the parity bit makes the count of ones in data plus parity even. With `par_even` at 0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R3: When `par_stick` and `par_en` are both 1, the parity bit is a constant. It is 0 when `par_even` is 1, and 1 when `par_even` is 0.
- R4: The line stays high for the stop period after the last data or parity bit. With `stop_sel` at 0 the stop period is 16 ticks. With `stop_sel` at 1 it is 32 ticks, except with 5-bit characters, where it is 24 ticks. `tx_empty` rises right after the last stop tick.
- R5: From the clock cycle after `brk` is sampled high, `txd` is low. Frame timing continues underneath. After `brk` is released, `txd` again shows the frame at its current position.
- R6: After reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R7: `hold_empty` is 1 exactly when the store holds no byte. `tx_empty` is 1 only when the store is empty and no frame is in progress. While `tx_empty` is 1 and `brk` is low, `txd` is high.
- R8: With `fifo_en` at 1, the store holds up to 16 bytes and sends them in the order they were written. A one-cycle `fifo_flush` pulse discards every stored byte. The frame already on the line is still completed.
- R9: A write to a full store is dropped, even in a cycle where a byte leaves the store. The store's contents do not change.
- R10: With `fifo_en` at 0, the store holds at most one byte. Any change of `fifo_en` discards the stored bytes.
- R11: The line-control inputs are captured when a frame starts. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding slot |
| fifo_flush | input | 1 | Pulse that discards stored bytes |
| bit_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| word_len | input | 2 | Character length code (5 to 8 bits) |
| stop_sel | input | 1 | Stop length select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Constant parity select |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Store is empty |
| tx_empty | output | 1 | Store empty and line idle |

## Verification
A wrong bit counter, a wrong shift order or a captured format that has gone stale shows up on `txd` within the same frame. It appears as a wrong level at the middle of some bit, and the frame length measured in ticks to the rise of `tx_empty` also comes out wrong. A faulty count in the store shows up later. The bytes come out reordered, duplicated or missing only when the queued frames drain, which can be many frames after the bad write. A store that overfills or empties wrongly also breaks the relation between `hold_empty` and `tx_empty` at once. A break path that does not act shows up as a high level on `txd` one cycle after `brk` is raised.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   localparam int unsigned CHAR_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       stop2;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
   } line_cfg_t;

   // number of data bits for a length code: 5..8
   function automatic logic [3:0] data_bits(input logic [1:0] wlen);
      return 4'd5 + {2'b00, wlen};
   endfunction

   // parity bit for the active data bits of a character
   function automatic logic parity_of(input logic [CHAR_W-1:0] d, input line_cfg_t c);
      logic [CHAR_W-1:0] m;
      m = 8'hFF >> (2'd3 - c.wlen);
      if (c.par_stick)
         return ~c.par_even;
      return c.par_even ? ^(d & m) : ~^(d & m);
   endfunction

endpackage

// File: rtl/async_tx_store.sv
module async_tx_store
   import async_tx_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter bit HAS_FIFO = 1'b1,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fifo_mode,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [CHAR_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic [CW-1:0]     occ
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (HAS_FIFO) begin : g_fifo
         logic [CHAR_W-1:0] mem [DEPTH];
         logic [AW-1:0]     wptr_q, rptr_q;
         logic [CW-1:0]     cnt_q;
         logic              push, pop;

         assign empty = (cnt_q == '0);
         assign full  = fifo_mode ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
         assign push  = wr_en & ~full;
         assign pop   = rd_en & ~empty;
         assign occ   = cnt_q;
         assign rd_data = mem[rptr_q];

         always_ff @(posedge clk) begin
            if (push)
               mem[wptr_q] <= wr_data;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               wptr_q <= '0;
               rptr_q <= '0;
               cnt_q  <= '0;
            end else begin
               if (push)
                  wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
               if (pop)
                  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
               case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
      end else begin : g_hold
         logic [CHAR_W-1:0] hold_q;
         logic              vld_q;

         assign empty   = ~vld_q;
         assign full    = vld_q;
         assign occ     = CW'(vld_q);
         assign rd_data = hold_q;

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               vld_q  <= 1'b0;
               hold_q <= '0;
            end else if (wr_en && !vld_q) begin
               vld_q  <= 1'b1;
               hold_q <= wr_data;
            end else if (rd_en) begin
               vld_q  <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
   import async_tx_pkg::*;
#(
   parameter int OS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              avail,
   input  logic [CHAR_W-1:0] data,
   input  line_cfg_t         cfg,
   input  logic              brk,
   output logic              take,
   output logic              txd,
   output logic              busy
);

   localparam int TW = $clog2(2 * OS);

   phase_e            phase_q, phase_d;
   logic [TW-1:0]     tcnt_q, tcnt_d, last_tick;
   logic [2:0]        bcnt_q, bcnt_d;
   logic [CHAR_W-1:0] sh_q, sh_d;
   line_cfg_t         cfg_q, cfg_d;
   logic              par_q, par_d;
   logic              line_d;
   logic              txd_q;

   // length of the current phase in ticks, minus one
   always_comb begin
      if (phase_q != PH_STOP)
         last_tick = TW'(OS - 1);
      else if (!cfg_q.stop2)
         last_tick = TW'(OS - 1);
      else if (cfg_q.wlen == 2'b00)
         last_tick = TW'(OS + OS / 2 - 1);
      else
         last_tick = TW'(2 * OS - 1);
   end

   always_comb begin
      phase_d = phase_q;
      tcnt_d  = tcnt_q;
      bcnt_d  = bcnt_q;
      sh_d    = sh_q;
      cfg_d   = cfg_q;
      par_d   = par_q;
      take    = 1'b0;
      if (phase_q == PH_IDLE) begin
         if (avail) begin
            take    = 1'b1;
            phase_d = PH_START;
            tcnt_d  = '0;
            bcnt_d  = '0;
            sh_d    = data;
            cfg_d   = cfg;
            par_d   = parity_of(data, cfg);
         end
      end else if (tick) begin
         if (tcnt_q != last_tick) begin
            tcnt_d = tcnt_q + 1'b1;
         end else begin
            tcnt_d = '0;
            case (phase_q)
               PH_START: phase_d = PH_DATA;
               PH_DATA: begin
                  if ({1'b0, bcnt_q} == data_bits(cfg_q.wlen) - 4'd1) begin
                     phase_d = cfg_q.par_en ? PH_PAR : PH_STOP;
                  end else begin
                     bcnt_d = bcnt_q + 1'b1;
                     sh_d   = {1'b0, sh_q[CHAR_W-1:1]};
                  end
               end
               PH_PAR:  phase_d = PH_STOP;
               default: phase_d = PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (phase_d)
         PH_START: line_d = 1'b0;
         PH_DATA:  line_d = sh_d[0];
         PH_PAR:   line_d = par_d;
         default:  line_d = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tcnt_q  <= '0;
         bcnt_q  <= '0;
         sh_q    <= '0;
         cfg_q   <= '0;
         par_q   <= 1'b0;
         txd_q   <= 1'b1;
      end else begin
         phase_q <= phase_d;
         tcnt_q  <= tcnt_d;
         bcnt_q  <= bcnt_d;
         sh_q    <= sh_d;
         cfg_q   <= cfg_d;
         par_q   <= par_d;
         txd_q   <= brk ? 1'b0 : line_d;
      end
   end

   assign txd  = txd_q;
   assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/async_tx.sv
module async_tx
   import async_tx_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int OS       = 16,
   parameter bit HAS_FIFO = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       fifo_en,
   input  logic       fifo_flush,
   input  logic       bit_tick,
   input  logic [1:0] word_len,
   input  logic       stop_sel,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       par_stick,
   input  logic       brk,
   output logic       txd,
   output logic       hold_empty,
   output logic       tx_empty
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("async_tx: DEPTH must be at least 2");
      end
      if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
         $error("async_tx: OS must be even and at least 4");
      end
   endgenerate

   logic              fifo_en_q;
   logic              flush_all;
   logic              st_empty, st_full, take, busy;
   logic [CW-1:0]     st_occ;
   logic [CHAR_W-1:0] st_data;
   line_cfg_t         cfg;

   always_ff @(posedge clk) begin
      if (!rst_n) fifo_en_q <= 1'b0;
      else        fifo_en_q <= fifo_en;
   end

   assign flush_all = fifo_flush | (fifo_en != fifo_en_q);

   assign cfg = '{wlen: word_len, stop2: stop_sel, par_en: par_en,
                  par_even: par_even, par_stick: par_stick};

   async_tx_store #(.DEPTH(DEPTH), .HAS_FIFO(HAS_FIFO)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_all),
      .fifo_mode(fifo_en),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (take),
      .rd_data  (st_data),
      .empty    (st_empty),
      .full     (st_full),
      .occ      (st_occ)
   );

   async_tx_frame #(.OS(OS)) u_frame (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (bit_tick),
      .avail(~st_empty),
      .data (st_data),
      .cfg  (cfg),
      .brk  (brk),
      .take (take),
      .txd  (txd),
      .busy (busy)
   );

   assign hold_empty = st_empty;
   assign tx_empty   = st_empty & ~busy;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
   parameter int DEPTH    = 16,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          brk,
   input logic          txd,
   input logic          hold_empty,
   input logic          tx_empty,
   input logic          wr_en,
   input logic          st_full,
   input logic [CW-1:0] st_occ,
   input logic          fifo_en
);

   p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(brk) |-> !txd);

   p_flag_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> hold_empty);

   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !$past(brk)) |-> txd);

   p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_occ <= CW'(DEPTH));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_full && wr_en) |-> (st_occ <= $past(st_occ)));

   p_single_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!fifo_en) && !fifo_en) |-> (st_occ <= CW'(1)));

endmodule

bind async_tx async_tx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .brk       (brk),
   .txd       (txd),
   .hold_empty(hold_empty),
   .tx_empty  (tx_empty),
   .wr_en     (wr_en),
   .st_full   (st_full),
   .st_occ    (st_occ),
   .fifo_en   (fifo_en)
);

// File: tb/async_tx_tb.sv
module async_tx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       fifo_en = 1'b0;
   logic       fifo_flush = 1'b0;
   logic       bit_tick = 1'b0;
   logic [1:0] word_len = 2'b11;
   logic       stop_sel = 1'b0;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic       par_stick = 1'b0;
   logic       brk = 1'b0;
   logic       txd, hold_empty, tx_empty;

   int  checks = 0;
   int  errors = 0;
   int  tick_total = 0;
   bit  tick_run = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   async_tx u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_en(fifo_en), .fifo_flush(fifo_flush), .bit_tick(bit_tick),
      .word_len(word_len), .stop_sel(stop_sel), .par_en(par_en),
      .par_even(par_even), .par_stick(par_stick), .brk(brk),
      .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
   );

   // tick every second cycle while running
   always @(negedge clk) begin
      if (tick_run) bit_tick <= ~bit_tick;
      else          bit_tick <= 1'b0;
   end

   always @(posedge clk) begin
      if (bit_tick) tick_total <= tick_total + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_tick(input int target);
      while (tick_total < target) @(negedge clk);
   endtask

   task automatic set_fmt(input int wl, input int st, input int pm);
      word_len  = 2'(wl);
      stop_sel  = (st != 0);
      par_en    = (pm != 0);
      par_even  = (pm == 2) || (pm == 3);
      par_stick = (pm >= 3);
   endtask

   function automatic logic exp_par(input logic [7:0] d, input int wl, input int pm);
      logic [7:0] m;
      m = 8'hFF >> (3 - wl);
      case (pm)
         1:       return ~^(d & m);
         2:       return ^(d & m);
         3:       return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   // decodes one frame at bit centres; optional length check via tx_empty
   task automatic expect_frame(input logic [7:0] d, input int wl, input int st,
                               input int pm, input bit check_len, input bit mid_change);
      int n, p, t0, tot, expt;
      n = 5 + wl;
      p = (pm != 0) ? 1 : 0;
      while (txd !== 1'b0) @(negedge clk);
      t0 = tick_total;
      if (mid_change) begin
         word_len = 2'b00;
         par_en   = 1'b1;
         stop_sel = 1'b1;
      end
      if (check_len)
         chk(hold_empty == 1'b1 && tx_empty == 1'b0, "R7 flags during frame",
             {hold_empty, tx_empty}, 2);
      wait_tick(t0 + 8);
      chk(txd == 1'b0, "R1 start bit", txd, 0);
      for (int i = 0; i < n; i++) begin
         wait_tick(t0 + 8 + 16 * (1 + i));
         chk(txd == d[i], "R1 data bit", txd, d[i]);
      end
      if (p != 0) begin
         wait_tick(t0 + 8 + 16 * (1 + n));
         chk(txd == exp_par(d, wl, pm), (pm >= 3) ? "R3 stick parity" : "R2 parity",
             txd, exp_par(d, wl, pm));
      end
      wait_tick(t0 + 8 + 16 * (1 + n + p));
      chk(txd == 1'b1, "R4 stop bit", txd, 1);
      if (st != 0 && wl != 0) begin
         wait_tick(t0 + 8 + 16 * (2 + n + p));
         chk(txd == 1'b1, "R4 second stop bit", txd, 1);
      end
      if (check_len) begin
         while (tx_empty !== 1'b1) @(negedge clk);
         tot  = tick_total - t0;
         expt = 16 * (1 + n + p) + ((st == 0) ? 16 : ((wl == 0) ? 24 : 32));
         chk(tot == expt, mid_change ? "R11 frame length" : "R4 frame length", tot, expt);
      end
   endtask

   task automatic check_idle(input string req);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (i % 25 == 0)
            chk(txd == 1'b1 && tx_empty == 1'b1, req, {txd, tx_empty}, 3);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1 && hold_empty == 1'b1 && tx_empty == 1'b1, "R6 reset state",
          {txd, hold_empty, tx_empty}, 7);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(txd == 1'b1 && hold_empty == 1'b1 && tx_empty == 1'b1, "R6 after reset",
          {txd, hold_empty, tx_empty}, 7);

      // full format sweep
      tick_run = 1'b1;
      for (int wl = 0; wl < 4; wl++)
         for (int st = 0; st < 2; st++)
            for (int pm = 0; pm < 5; pm++) begin
               logic [7:0] d;
               d = 8'(8'h35 + wl * 61 + st * 29 + pm * 17);
               set_fmt(wl, st, pm);
               send(d);
               expect_frame(d, wl, st, pm, 1'b1, 1'b0);
            end

      // R11: format change mid-frame
      set_fmt(3, 0, 0);
      send(8'hA5);
      expect_frame(8'hA5, 3, 0, 0, 1'b1, 1'b1);
      set_fmt(3, 0, 0);

      // R5: break during a frame
      send(8'hFF);
      while (txd !== 1'b0) @(negedge clk);
      t0 = tick_total;
      wait_tick(t0 + 40);
      brk = 1'b1;
      @(negedge clk);
      chk(txd == 1'b0, "R5 break next cycle", txd, 0);
      wait_tick(t0 + 8 + 16 * 4);
      chk(txd == 1'b0, "R5 break over data", txd, 0);
      brk = 1'b0;
      wait_tick(t0 + 8 + 16 * 6);
      chk(txd == 1'b1, "R5 frame resumes", txd, 1);
      while (tx_empty !== 1'b1) @(negedge clk);
      chk(tick_total - t0 == 160, "R5 timing unchanged", tick_total - t0, 160);
      brk = 1'b1;
      repeat (3) @(negedge clk);
      chk(txd == 1'b0, "R5 break while idle", txd, 0);
      brk = 1'b0;
      @(negedge clk);

      // R8/R9: fill the queue past capacity
      fifo_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_run = 1'b0;
      send(8'h10);
      for (int i = 1; i <= 17; i++) begin
         wr_en   = 1'b1;
         wr_data = 8'(8'h20 + i * 7);
         @(negedge clk);
      end
      wr_en = 1'b0;
      @(negedge clk);
      chk(hold_empty == 1'b0 && tx_empty == 1'b0, "R7 flags with queue loaded",
          {hold_empty, tx_empty}, 0);
      tick_run = 1'b1;
      expect_frame(8'h10, 3, 0, 0, 1'b0, 1'b0);
      for (int i = 1; i <= 16; i++)
         expect_frame(8'(8'h20 + i * 7), 3, 0, 0, (i == 16), 1'b0);
      check_idle("R9 overflow byte dropped");

      // R8: flush keeps frame in flight
      tick_run = 1'b0;
      send(8'h3C);
      send(8'h44);
      send(8'h55);
      fifo_flush = 1'b1;
      @(negedge clk);
      fifo_flush = 1'b0;
      chk(hold_empty == 1'b1 && tx_empty == 1'b0, "R8 flush clears store",
          {hold_empty, tx_empty}, 2);
      tick_run = 1'b1;
      expect_frame(8'h3C, 3, 0, 0, 1'b1, 1'b0);
      check_idle("R8 nothing after flush");

      // R10/R9: single holding slot
      fifo_en = 1'b0;
      repeat (3) @(negedge clk);
      tick_run = 1'b0;
      send(8'h61);
      send(8'h72);
      chk(hold_empty == 1'b0, "R10 slot holds one byte", hold_empty, 0);
      send(8'h83);
      tick_run = 1'b1;
      expect_frame(8'h61, 3, 0, 0, 1'b0, 1'b0);
      expect_frame(8'h72, 3, 0, 0, 1'b1, 1'b0);
      check_idle("R9 write to full slot dropped");

      // R10: mode change empties the store
      fifo_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_run = 1'b0;
      send(8'h9A);
      send(8'hB4);
      send(8'hC7);
      fifo_en = 1'b0;
      @(negedge clk);
      chk(hold_empty == 1'b1, "R10 mode change empties store", hold_empty, 1);
      tick_run = 1'b1;
      expect_frame(8'h9A, 3, 0, 0, 1'b1, 1'b0);
      check_idle("R10 no stale bytes");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule